// File: doc/BRIEF.md
# Decode-Stage Interlock and Flush Controller

This block decides, every cycle, whether the front of a five-stage in-order integer pipeline must wait and whether the instruction sitting between fetch and decode must be discarded. Branch comparisons and register-indirect jump targets are computed in the decode stage. Because of this, the instruction in decode sometimes needs a value that forwarding cannot yet supply. The block looks at the decode-stage source fields and at the destination and control flags carried by the execute-stage and memory-stage pipeline registers. From these it produces three combinational controls.

The first control holds the program counter and the fetch/decode register. The second turns the next execute-stage entry into a no-op bubble. The third flushes the fetch/decode register when a control transfer resolved in decode is taken, so a taken transfer costs one cycle. The forwarding multiplexers sit elsewhere and are not part of this block.

Top module: `hazard_ctrl`

## Requirements
- R1: When a used, non-zero source of the decode instruction equals the destination of a register-writing load in execute, `hold_front` and `ins_bubble` are both 1 in the same cycle.
- R2: When a used, non-zero source of the decode instruction equals the destination of a register-writing register-indirect jump in execute, `hold_front` and `ins_bubble` are both 1.
- R3: A register-indirect jump in decode (`id_is_jalr`=1) whose used source equals the destination of a load in the memory stage raises a stall. The same match raises no stall for a decode instruction with `id_is_jalr`=0.
- R4: A source index of 0 never raises a stall, even if an older instruction names register 0 as a load destination.
- R5: A source field whose `used` flag is 0 never raises a stall.
- R6: An execute-stage instruction that is neither a load nor a register-indirect jump, or whose register-write flag is 0, raises no stall.
- R7: `hold_front` and `ins_bubble` are always equal.
- R8: With no stall condition, `id_jump_taken`=1 gives `flush_ifid`=1 and no stall. With `id_jump_taken`=0, `flush_ifid` is 0.
- R9: When a stall condition and `id_jump_taken` are both present, the stall is raised and `flush_ifid` is 0. Once the hazard clears, the flush is raised.
- R10: Both source fields (rs1 and rs2) are checked independently against each older stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register index of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2 | input | 5 | Second source register index of the decode instruction |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_jalr | input | 1 | Decode instruction is a register-indirect jump |
| id_jump_taken | input | 1 | Control transfer resolved in decode is taken |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_is_jalr | input | 1 | Execute-stage instruction is a register-indirect jump |
| mem_rd | input | 5 | Destination index of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| hold_front | output | 1 | Freeze program counter and fetch/decode register |
| ins_bubble | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid | output | 1 | Discard the instruction in the fetch/decode register |

## Verification
The bench builds the block with its default five-bit register index and two decode sources, which puts the zero register, both source fields and every older-stage flag within reach of directed stimulus. The scenarios place matching and non-matching destinations against each source in turn. They clear the used flags and the write flag one at a time, and they align a taken transfer with a live load dependency over two cycles. This shows the flush being deferred and then issued.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_AW  = 5;
    localparam int NUM_SRC = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        reg_idx_t rd;
        logic     wr_en;
        logic     is_load;
        logic     is_jalr;
    } ex_slot_t;

    typedef struct packed {
        reg_idx_t rd;
        logic     is_load;
    } mem_slot_t;

    typedef struct packed {
        reg_idx_t idx;
        logic     used;
    } src_t;

    function automatic logic src_live(src_t s);
        return s.used && (s.idx != '0);
    endfunction
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
(
    input  src_t      src,
    input  ex_slot_t  ex,
    input  mem_slot_t mem,
    output logic      ex_hit,
    output logic      mem_hit
);
    logic live;
    logic ex_late;

    always_comb begin
        live    = src_live(src);
        ex_late = ex.wr_en && (ex.is_load || ex.is_jalr);
        ex_hit  = live && ex_late && (ex.rd == src.idx);
        mem_hit = live && mem.is_load && (mem.rd == src.idx);
    end

    always_comb begin
        // R4
        zero_src_chk: assert ((src.idx != '0) || (!ex_hit && !mem_hit));
        // R5
        unused_src_chk: assert (src.used || (!ex_hit && !mem_hit));
    end
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
    import hz_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] ex_hits,
    input  logic [N-1:0] mem_hits,
    input  logic         dec_jalr,
    input  logic         jump_taken,
    output logic         hold,
    output logic         bubble,
    output logic         flush
);
    logic stall;

    always_comb begin
        stall  = (|ex_hits) || (dec_jalr && (|mem_hits));
        hold   = stall;
        bubble = stall;
        flush  = jump_taken && !stall;
    end

    always_comb begin
        // R9
        flush_excl_chk: assert (!(flush && hold));
        // R8
        flush_cause_chk: assert (!flush || jump_taken);
        // R3
        mem_jalr_only_chk: assert (!hold || (|ex_hits) || dec_jalr);
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic       id_rs1_used,
    input  logic [4:0] id_rs2,
    input  logic       id_rs2_used,
    input  logic       id_is_jalr,
    input  logic       id_jump_taken,
    input  logic [4:0] ex_rd,
    input  logic       ex_reg_write,
    input  logic       ex_mem_read,
    input  logic       ex_is_jalr,
    input  logic [4:0] mem_rd,
    input  logic       mem_mem_read,
    output logic       hold_front,
    output logic       ins_bubble,
    output logic       flush_ifid
);
    src_t             srcs [NUM_SRC];
    ex_slot_t         ex_s;
    mem_slot_t        mem_s;
    logic [NUM_SRC-1:0] ex_hits;
    logic [NUM_SRC-1:0] mem_hits;

    always_comb begin
        srcs[0] = '{idx: id_rs1, used: id_rs1_used};
        srcs[1] = '{idx: id_rs2, used: id_rs2_used};
        ex_s    = '{rd: ex_rd, wr_en: ex_reg_write,
                    is_load: ex_mem_read, is_jalr: ex_is_jalr};
        mem_s   = '{rd: mem_rd, is_load: mem_mem_read};
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_src_match u_match (
            .src     (srcs[g]),
            .ex      (ex_s),
            .mem     (mem_s),
            .ex_hit  (ex_hits[g]),
            .mem_hit (mem_hits[g])
        );
    end

    hz_arbiter #(.N(NUM_SRC)) u_arb (
        .ex_hits    (ex_hits),
        .mem_hits   (mem_hits),
        .dec_jalr   (id_is_jalr),
        .jump_taken (id_jump_taken),
        .hold       (hold_front),
        .bubble     (ins_bubble),
        .flush      (flush_ifid)
    );

    always_comb begin
        // R6
        ex_kind_chk: assert (!hold_front || mem_mem_read ||
                             (ex_reg_write && (ex_mem_read || ex_is_jalr)));
        // R7
        hold_pair_chk: assert (hold_front == ins_bubble);
        // R4
        both_zero_chk: assert (!((id_rs1 == '0) && (id_rs2 == '0)) || !hold_front);
    end
endmodule

// File: tb/hazard_ctrl_tb_top.sv
module hazard_ctrl_tb_top;
    logic clk = 0;
    always #5 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd;
    logic id_rs1_used, id_rs2_used, id_is_jalr, id_jump_taken;
    logic ex_reg_write, ex_mem_read, ex_is_jalr, mem_mem_read;
    logic hold_front, ins_bubble, flush_ifid;

    int n_chk = 0;
    int n_bad = 0;

    hazard_ctrl dut_i (.*);

    task automatic idle();
        id_rs1 = 0; id_rs1_used = 0; id_rs2 = 0; id_rs2_used = 0;
        id_is_jalr = 0; id_jump_taken = 0;
        ex_rd = 0; ex_reg_write = 0; ex_mem_read = 0; ex_is_jalr = 0;
        mem_rd = 0; mem_mem_read = 0;
    endtask

    task automatic expect3(string tag, logic h, logic b, logic f);
        @(negedge clk); #1;
        n_chk++;
        if (hold_front !== h || ins_bubble !== b || flush_ifid !== f) begin
            n_bad++;
            $display("FAIL %s: got hold=%b bubble=%b flush=%b, expected %b %b %b",
                     tag, hold_front, ins_bubble, flush_ifid, h, b, f);
        end
    endtask

    task automatic t_reset_state();
        idle();
        expect3("R6 idle", 0, 0, 0);
    endtask

    task automatic t_load_ex();
        idle(); ex_rd = 5; ex_reg_write = 1; ex_mem_read = 1;
        id_rs1 = 5; id_rs1_used = 1;
        expect3("R1 load rs1", 1, 1, 0);
        id_rs1 = 6;
        expect3("R1 load mismatch", 0, 0, 0);
        id_rs2 = 5; id_rs2_used = 1;
        expect3("R10 load rs2", 1, 1, 0);
    endtask

    task automatic t_jalr_ex();
        idle(); ex_rd = 7; ex_reg_write = 1; ex_is_jalr = 1;
        id_rs2 = 7; id_rs2_used = 1;
        expect3("R2 jalr in ex", 1, 1, 0);
    endtask

    task automatic t_plain_ex();
        idle(); ex_rd = 5; ex_reg_write = 1;
        id_rs1 = 5; id_rs1_used = 1;
        expect3("R6 alu in ex", 0, 0, 0);
        ex_mem_read = 1; ex_reg_write = 0;
        expect3("R6 no write flag", 0, 0, 0);
    endtask

    task automatic t_mem_load();
        idle(); mem_rd = 9; mem_mem_read = 1;
        id_rs1 = 9; id_rs1_used = 1; id_is_jalr = 1;
        expect3("R3 jalr vs mem load", 1, 1, 0);
        id_is_jalr = 0;
        expect3("R3 non-jalr vs mem load", 0, 0, 0);
    endtask

    task automatic t_zero_reg();
        idle(); ex_rd = 0; ex_reg_write = 1; ex_mem_read = 1;
        id_rs1 = 0; id_rs1_used = 1; id_rs2 = 0; id_rs2_used = 1;
        expect3("R4 x0 source", 0, 0, 0);
    endtask

    task automatic t_unused();
        idle(); ex_rd = 5; ex_reg_write = 1; ex_mem_read = 1;
        id_rs1 = 5; id_rs1_used = 0; id_rs2 = 5; id_rs2_used = 0;
        expect3("R5 unused fields", 0, 0, 0);
    endtask

    task automatic t_flush();
        idle(); id_jump_taken = 1;
        expect3("R8 taken flush", 0, 0, 1);
    endtask

    task automatic t_collide();
        idle(); id_jump_taken = 1; id_is_jalr = 1;
        ex_rd = 3; ex_reg_write = 1; ex_mem_read = 1;
        id_rs1 = 3; id_rs1_used = 1;
        expect3("R9 stall beats flush", 1, 1, 0);
        ex_rd = 0; ex_reg_write = 0; ex_mem_read = 0;
        mem_rd = 3; mem_mem_read = 1;
        expect3("R9 still waiting on mem load", 1, 1, 0);
        mem_mem_read = 0;
        expect3("R9 deferred flush", 0, 0, 1);
    endtask

    initial begin : watchdog
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        t_reset_state();
        t_load_ex();
        t_jalr_ex();
        t_plain_ex();
        t_mem_load();
        t_zero_reg();
        t_unused();
        t_flush();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule